// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break and Resync Recovery

This block turns an asynchronous serial line into characters. It samples the line on a sample enable that runs at sixteen times the bit rate. It confirms a start bit at its centre and samples each data bit, the optional parity bit and the first stop bit at their centres. Each finished character is handed out as a byte with three tags: parity error, framing error and break. A one-cycle valid strobe marks the character. The frame shape comes from four static settings: word length, stop-bit count, parity enable and parity sense. These settings change only while the line is idle.

The receiver also handles two abnormal line conditions. A low stop bit is reported as a framing error. That low level is then taken as the start bit of the next frame, so the receiver can lock back onto a stream that was misaligned. A line held low for longer than one whole frame is reported as one all-zero break character. After that, the line must go high for a short time before a new frame is accepted.

Top module: `urx_receiver`

## Requirements
- R1: After a falling edge is seen on a tick, the start bit is accepted only if the line is still low on the 8th tick after that edge tick. Otherwise the receiver returns to idle and emits nothing.
- R2: `cfg_wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data is received LSB first, and `rx_data` bits at or above the word length read 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `rx_perr`. With `cfg_par_en`=0 there is no parity bit and `rx_perr` is always 0.
- R4: Only the first stop bit is sampled. `cfg_two_stop` changes only the frame length used for break detection.
- R5: `rx_valid` is high for exactly one clock cycle. For a frame received normally, it rises in the cycle after the tick that samples the stop-bit centre, which is 8+16*(bits after start) ticks after the edge tick. The data and tags hold until the next character.
- R6: A low stop bit in a frame that is not entirely low gives a character with `rx_ferr`=1. If the line then stays low on the next two ticks, that low level is treated as a confirmed start bit, and data sampling continues 16 ticks after the stop centre. If not, the receiver goes idle.
- R7: A line that stays low for more than W ticks gives exactly one character: data 0, `rx_brk`=1, `rx_ferr`=0, `rx_perr`=0. Here W = 16 * (1 + data bits + parity bits + stop bits).
- R8: A frame that is low from start to stop, on a line that rises within W low ticks, gives one character on the tick where the line rises: data 0, `rx_ferr`=1, and `rx_perr` set by the R3 rule for a parity bit of 0.
- R9: After a break, a new start bit is accepted only after the line has been high on two consecutive ticks. A single high tick does not re-arm the receiver.
- R10: During and right after reset, `rx_valid`, `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| tick_en | input | 1 | Sample enable, 16 per bit time, one clock wide |
| cfg_wlen | input | 2 | Word length select, 0..3 for 5..8 bits |
| cfg_two_stop | input | 1 | 1 for two stop bits in the frame length |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_data | output | DATA_W | Received character, right aligned |
| rx_perr | output | 1 | Parity error tag |
| rx_ferr | output | 1 | Framing error tag |
| rx_brk | output | 1 | Break tag |

## Verification
Framing-error reporting and start-bit detection can land on the same tick, because the stop-centre sample that flags the error also begins the next frame. The bench holds the stop bit low for 10, 11 and 16 ticks, in some cases followed by another frame's data. It then compares the framing character and any following character against its model. Break detection and the framing report for an all-low frame meet at one tick count: holding the line low for exactly W ticks must give a framing character, and W+1 ticks must give a break. This boundary is driven for two frame lengths.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_RESYNC,
        ST_LOWHOLD,
        ST_BRKWAIT
    } urx_state_e;

    // Number of bit slots in one frame: start + data + parity + stop
    function automatic int frame_slots(input int data_bits, input logic par_en,
                                       input logic two_stop);
        return 1 + data_bits + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb pipe_d = d;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/urx_low_run.sv
module urx_low_run #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic [RUN_W-1:0] limit,
    output logic             run_over
);

    logic [RUN_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (tick) begin
            if (line)                run_d = '0;
            else if (run_q != '1)    run_d = run_q + 1'b1;
        end
        // this tick is low and the low run already covers the limit
        run_over = tick && !line && (run_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

endmodule

// File: rtl/urx_parity.sv
module urx_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         even_sel,
    input  logic         par_bit,
    output logic         mismatch
);

    logic expected;

    always_comb begin
        expected = even_sel ? (^data) : ~(^data);
        mismatch = (par_bit != expected);
    end

endmodule

// File: rtl/urx_receiver.sv
module urx_receiver
    import urx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              tick_en,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk
);

    localparam int CNT_W  = $clog2(OSR);
    localparam int MID    = OSR / 2;
    localparam int NB_W   = $clog2(DATA_W + 1);
    localparam int MIN_WL = DATA_W - 3;
    localparam int RUN_W  = $clog2(OSR * (DATA_W + 4) + 1);

    typedef struct packed {
        urx_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [NB_W-1:0]   nbit;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic              rx_s;
    logic [NB_W-1:0]   word_len;
    logic [NB_W-1:0]   last_idx;
    logic [RUN_W-1:0]  word_ticks;
    logic [DATA_W-1:0] aligned;
    logic              par_mismatch;
    logic              brk_hit;
    logic              bit_end;
    logic              mid_hit;
    logic              all_low;

    urx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_s)
    );

    always_comb begin
        word_len   = NB_W'(MIN_WL) + NB_W'(cfg_wlen);
        last_idx   = word_len - NB_W'(1);
        word_ticks = RUN_W'(OSR * frame_slots(int'(word_len), cfg_par_en, cfg_two_stop));
        aligned    = r_q.sh >> (DATA_W - int'(word_len));
        bit_end    = (r_q.cnt == CNT_W'(OSR - 1));
        mid_hit    = (r_q.cnt == CNT_W'(MID - 1));
        all_low    = (aligned == '0) && (!cfg_par_en || !r_q.pbit);
    end

    urx_low_run #(.RUN_W(RUN_W)) u_low_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .line     (rx_s),
        .limit    (word_ticks),
        .run_over (brk_hit)
    );

    urx_parity #(.W(DATA_W)) u_parity (
        .data     (aligned),
        .even_sel (cfg_par_even),
        .par_bit  (r_q.pbit),
        .mismatch (par_mismatch)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (tick_en) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!rx_s) begin
                        r_d.st  = ST_START;
                        r_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (mid_hit) begin
                        if (!rx_s) begin
                            r_d.st   = ST_DATA;
                            r_d.cnt  = '0;
                            r_d.nbit = '0;
                            r_d.sh   = '0;
                            r_d.pbit = 1'b0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        r_d.cnt  = '0;
                        r_d.sh   = {rx_s, r_q.sh[DATA_W-1:1]};
                        r_d.nbit = r_q.nbit + 1'b1;
                        if (r_q.nbit == last_idx)
                            r_d.st = cfg_par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (bit_end) begin
                        r_d.cnt  = '0;
                        r_d.pbit = rx_s;
                        r_d.st   = ST_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        r_d.cnt = '0;
                        if (rx_s) begin
                            r_d.valid = 1'b1;
                            r_d.data  = aligned;
                            r_d.perr  = cfg_par_en && par_mismatch;
                            r_d.ferr  = 1'b0;
                            r_d.brk   = 1'b0;
                            r_d.st    = ST_IDLE;
                        end else if (all_low) begin
                            r_d.st = ST_LOWHOLD;
                        end else begin
                            r_d.valid = 1'b1;
                            r_d.data  = aligned;
                            r_d.perr  = cfg_par_en && par_mismatch;
                            r_d.ferr  = 1'b1;
                            r_d.brk   = 1'b0;
                            r_d.st    = ST_RESYNC;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_RESYNC: begin
                    if (rx_s) begin
                        r_d.st = ST_IDLE;
                    end else if (r_q.cnt == CNT_W'(1)) begin
                        // two low samples confirm: act as start-bit centre + 2
                        r_d.st   = ST_DATA;
                        r_d.cnt  = CNT_W'(2);
                        r_d.nbit = '0;
                        r_d.sh   = '0;
                        r_d.pbit = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_LOWHOLD: begin
                    if (brk_hit) begin
                        r_d.valid = 1'b1;
                        r_d.data  = '0;
                        r_d.perr  = 1'b0;
                        r_d.ferr  = 1'b0;
                        r_d.brk   = 1'b1;
                        r_d.cnt   = '0;
                        r_d.st    = ST_BRKWAIT;
                    end else if (rx_s) begin
                        r_d.valid = 1'b1;
                        r_d.data  = '0;
                        r_d.perr  = cfg_par_en && par_mismatch;
                        r_d.ferr  = 1'b1;
                        r_d.brk   = 1'b0;
                        r_d.st    = ST_IDLE;
                    end
                end
                ST_BRKWAIT: begin
                    if (!rx_s)                       r_d.cnt = '0;
                    else if (r_q.cnt == CNT_W'(1))   r_d.st  = ST_IDLE;
                    else                             r_d.cnt = r_q.cnt + 1'b1;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_valid = r_q.valid;
    assign rx_data  = r_q.data;
    assign rx_perr  = r_q.perr;
    assign rx_ferr  = r_q.ferr;
    assign rx_brk   = r_q.brk;

endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [1:0]        cfg_wlen,
    input logic              cfg_par_en,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_perr,
    input logic              rx_ferr,
    input logic              rx_brk
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5

    AST_VALID_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick_en)); // R5

    AST_BREAK_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == '0)); // R7

    AST_BREAK_NO_OTHER_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (!rx_ferr && !rx_perr)); // R7

    AST_NO_PARITY_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !rx_perr); // R3

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (DATA_W - 3 + int'(cfg_wlen))) == '0)); // R2

endmodule

bind urx_receiver urx_checker #(.DATA_W(DATA_W)) u_urx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cfg_wlen   (cfg_wlen),
    .cfg_par_en (cfg_par_en),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr),
    .rx_brk     (rx_brk)
);

// File: tb/tb_urx_receiver.sv
module tb_urx_receiver;

    localparam int OSR    = 16;
    localparam int DATA_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic              rx_perr, rx_ferr, rx_brk;

    always #2 clk = ~clk;

    urx_receiver #(.OSR(OSR), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick_en(tick_en),
        .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    int     n_checks = 0;
    int     n_fail = 0;
    longint tick_count = 0;

    logic [7:0] cap_data [0:511];
    bit         cap_pe [0:511], cap_fe [0:511], cap_brk [0:511];
    longint     cap_tick [0:511];
    int         ncap = 0;
    int         pulse_errs = 0;

    logic [7:0] exp_data [0:511];
    bit         exp_pe [0:511], exp_fe [0:511], exp_brk [0:511];
    string      exp_req [0:511];
    int         nexp = 0;
    int         ci = 0, ei = 0;

    // sample enable: one clock in four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick_en = (ph == 0);
            ph = (ph + 1) % 4;
        end
    end

    initial forever begin
        @(posedge clk);
        if (tick_en) tick_count++;
    end

    initial begin
        bit prev_v = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_valid && ncap < 512) begin
                cap_data[ncap] = rx_data;
                cap_pe[ncap]   = rx_perr;
                cap_fe[ncap]   = rx_ferr;
                cap_brk[ncap]  = rx_brk;
                cap_tick[ncap] = tick_count;
                ncap++;
            end
            if (rx_valid && prev_v) pulse_errs++;
            prev_v = rx_valid;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe,
                               input bit brk, input string req);
        exp_data[nexp] = d;
        exp_pe[nexp]   = pe;
        exp_fe[nexp]   = fe;
        exp_brk[nexp]  = brk;
        exp_req[nexp]  = req;
        nexp++;
    endtask

    task automatic compare(input string req);
        int got  = ncap - ci;
        int want = nexp - ei;
        check(got == want, req, "character count", got, want);
        for (int k = 0; k < want && k < got; k++) begin
            check({cap_brk[ci+k], cap_fe[ci+k], cap_pe[ci+k], cap_data[ci+k]} ==
                  {exp_brk[ei+k], exp_fe[ei+k], exp_pe[ei+k], exp_data[ei+k]},
                  exp_req[ei+k], "{brk,fe,pe,data}",
                  {cap_brk[ci+k], cap_fe[ci+k], cap_pe[ci+k], cap_data[ci+k]},
                  {exp_brk[ei+k], exp_fe[ei+k], exp_pe[ei+k], exp_data[ei+k]});
        end
        ci = ncap;
        ei = nexp;
    endtask

    // drive a level for n ticks, return at the negedge after the last tick
    task automatic hold(input logic lvl, input int n);
        rx_in = lvl;
        for (int k = 0; k < n; ) begin
            @(posedge clk);
            if (tick_en) k++;
        end
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] wl, input bit two, input bit pen, input bit peven);
        cfg_wlen     = wl;
        cfg_two_stop = two;
        cfg_par_en   = pen;
        cfg_par_even = peven;
    endtask

    function automatic int wbits();
        return 5 + int'(cfg_wlen);
    endfunction

    function automatic logic [7:0] wmask();
        return 8'hFF >> (8 - wbits());
    endfunction

    function automatic logic good_par(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

    task automatic send_frame(input logic [7:0] d, input bit flip_par,
                              input logic stop_lvl, input int stop_ticks);
        logic [7:0] dm = d & wmask();
        hold(1'b0, OSR);
        for (int i = 0; i < wbits(); i++) hold(dm[i], OSR);
        if (cfg_par_en) hold(good_par(dm, cfg_par_even) ^ flip_par, OSR);
        hold(stop_lvl, stop_ticks);
    endtask

    initial begin
        longint t0;
        void'($urandom(32'd4711));

        // R10: reset state
        repeat (6) @(negedge clk);
        check({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == '0, "R10",
              "outputs in reset", {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
        rst_n = 1'b1;
        hold(1'b1, 40);
        check({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == '0, "R10",
              "outputs after reset", {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);

        // R5: 8N1 frame, strobe on the stop-centre tick
        set_cfg(2'd3, 0, 0, 0);
        t0 = tick_count;
        expect_char(8'hA5, 0, 0, 0, "R5");
        send_frame(8'hA5, 0, 1'b1, OSR);
        hold(1'b1, 32);
        if (ncap > ci)
            check(cap_tick[ci] == t0 + 25 + 16 * 8, "R5", "strobe tick",
                  cap_tick[ci], t0 + 25 + 16 * 8);
        compare("R5");

        // R2: shorter words, LSB first, upper bits zero
        for (int wl = 0; wl < 3; wl++) begin
            set_cfg(2'(wl), 0, 0, 0);
            expect_char(8'hEB & wmask(), 0, 0, 0, "R2");
            send_frame(8'hEB, 0, 1'b1, OSR);
            expect_char(8'h35 & wmask(), 0, 0, 0, "R2");
            send_frame(8'h35, 0, 1'b1, OSR);
            hold(1'b1, 20);
            compare("R2");
        end

        // R3: parity even/odd, good and flipped
        set_cfg(2'd3, 0, 1, 1);
        expect_char(8'h37, 0, 0, 0, "R3"); send_frame(8'h37, 0, 1'b1, OSR);
        expect_char(8'h37, 1, 0, 0, "R3"); send_frame(8'h37, 1, 1'b1, OSR);
        set_cfg(2'd2, 0, 1, 0);
        expect_char(8'h37 & 8'h7F, 0, 0, 0, "R3"); send_frame(8'h37, 0, 1'b1, OSR);
        expect_char(8'h37 & 8'h7F, 1, 0, 0, "R3"); send_frame(8'h37, 1, 1'b1, OSR);
        hold(1'b1, 20);
        compare("R3");

        // R1: start glitch of 8 ticks is rejected, 9 ticks is accepted
        set_cfg(2'd3, 0, 0, 0);
        hold(1'b0, 8);
        hold(1'b1, 200);
        compare("R1");
        hold(1'b0, 9);
        expect_char(8'hFF, 0, 0, 0, "R1");
        hold(1'b1, 200);
        compare("R1");

        // R6: low stop then idle; the low level resyncs into an all-ones char
        expect_char(8'h3C, 0, 1, 0, "R6");
        expect_char(8'hFF, 0, 0, 0, "R6");
        send_frame(8'h3C, 0, 1'b0, OSR);
        hold(1'b1, 200);
        compare("R6");

        // R6: low stop is the start of a following frame
        begin
            logic [7:0] nxt = 8'h5A;
            expect_char(8'h3C, 0, 1, 0, "R6");
            expect_char(8'h5A, 0, 0, 0, "R6");
            send_frame(8'h3C, 0, 1'b0, OSR);
            for (int i = 0; i < 8; i++) hold(nxt[i], OSR);
            hold(1'b1, 100);
            compare("R6");
        end

        // R6: stop low 10 ticks -> second sample high -> idle
        expect_char(8'h3C, 0, 1, 0, "R6");
        send_frame(8'h3C, 0, 1'b0, 10);
        hold(1'b1, 200);
        compare("R6");
        // stop low 11 ticks -> both samples low -> resync
        expect_char(8'h3C, 0, 1, 0, "R6");
        expect_char(8'hFF, 0, 0, 0, "R6");
        send_frame(8'h3C, 0, 1'b0, 11);
        hold(1'b1, 200);
        compare("R6");

        // R8: all-low 8N1 frame for exactly W=160 ticks
        hold(1'b0, 160);
        expect_char(8'h00, 0, 1, 0, "R8");
        hold(1'b1, 60);
        compare("R8");
        // R8: 7O1, W=160, parity bit 0 mismatches odd parity
        set_cfg(2'd2, 0, 1, 0);
        hold(1'b0, 160);
        expect_char(8'h00, 1, 1, 0, "R8");
        hold(1'b1, 60);
        compare("R8");

        // R7 + R9: W+1 low ticks -> break; one high tick does not re-arm
        set_cfg(2'd3, 0, 0, 0);
        hold(1'b0, 161);
        expect_char(8'h00, 0, 0, 1, "R7");
        hold(1'b1, 1);
        hold(1'b0, 30);
        hold(1'b1, 30);
        expect_char(8'h81, 0, 0, 0, "R9");
        send_frame(8'h81, 0, 1'b1, OSR);
        hold(1'b1, 40);
        compare("R9");

        // R4: 8E2 frame length W=192 decides framing vs break
        set_cfg(2'd3, 1, 1, 1);
        hold(1'b0, 192);
        expect_char(8'h00, 0, 1, 0, "R4");
        hold(1'b1, 60);
        compare("R4");
        hold(1'b0, 193);
        expect_char(8'h00, 0, 0, 1, "R4");
        // R9: exactly two high ticks then a frame is accepted
        hold(1'b1, 2);
        expect_char(8'h42, 0, 0, 0, "R9");
        send_frame(8'h42, 0, 1'b1, 2 * OSR);
        hold(1'b1, 40);
        compare("R9");

        // R7: long low yields a single break character
        set_cfg(2'd3, 0, 0, 0);
        hold(1'b0, 500);
        expect_char(8'h00, 0, 0, 1, "R7");
        hold(1'b1, 60);
        compare("R7");

        // random frames across all settings
        for (int f = 0; f < 40; f++) begin
            logic [7:0] d    = 8'($urandom % 256);
            bit         flip = ($urandom % 4) == 0;
            set_cfg(2'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));
            expect_char(d & wmask(), cfg_par_en && flip, 0, 0, "R3");
            send_frame(d, flip, 1'b1, cfg_two_stop ? 2 * OSR : OSR);
            hold(1'b1, int'($urandom % 20));
        end
        hold(1'b1, 40);
        compare("R2");

        check(pulse_errs == 0, "R5", "strobe wider than one cycle", pulse_errs, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog: actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule